// File: doc/BRIEF.md
# Gated Event Counter with Gate Conditioning

This block is a wrap-around up-counter whose increments can be qualified by a conditioned gate signal. The gate comes from a dedicated pin or from one of two comparator outputs. Each comparator output either passes through a synchronizer clocked by the counter clock or goes straight to the selector. The selected gate can be inverted. It can then be folded through a toggle stage, so that a whole gate period opens the count window instead of a single level. A one-shot arm/done handshake can also limit counting to a single gate pulse or a single period per arm.

Software sees the live conditioned gate level and the arm/done bit. It also sees a sticky event flag that is raised whenever the conditioned gate falls, and an interrupt request that is that flag masked by an enable. The gate level and the flag work whether or not gating of the counter is switched on. A typical use is to arm the one-shot, wait for done, and read the count as a pulse width or a period in counter clocks.

Top module: `gated_counter`

## Requirements
- R1: After reset, the count, the arm/done bit, the event flag and the interrupt request are all zero.
- R2: On each clock edge the count is loaded from the write data if the write strobe is high. Otherwise it rises by one, wrapping to zero past its maximum, when the count enable is on and either gating is off or the conditioned gate is high. Otherwise it holds.
- R3: The gate selector picks a source by code: 0 is the pin, 1 is comparator A (bit 0 of the comparator bus), 2 is comparator B (bit 1), and 3 is a constant low. Sources that are not selected have no effect.
- R4: With its sync bit set, a comparator output reaches the gate after SYNC_STAGES counter clock edges. With the bit clear it reaches the gate directly.
- R5: With the polarity bit set, the selected gate is inverted ahead of the toggle stage, so counting happens while the raw source is low.
- R6: In toggle mode, a flip-flop changes state on every rising edge of the polarized gate and replaces it as the gate. One full source period is counted between two rising edges.
- R7: While toggle mode is off, the toggle flip-flop is cleared and held at zero, so re-enabling toggle mode always starts from the low state.
- R8: In single-pulse mode, a go strobe sets the arm/done bit. Counting opens on the next rising edge of the gate after the toggle stage. On that gate's falling edge the bit clears itself, and later gate pulses do not count until the bit is set again.
- R9: While single-pulse mode is off, the arm/done bit is forced to zero and go strobes are ignored.
- R10: The gate-value output always shows the conditioned gate level, including while gating of the counter is off.
- R11: The event flag is set by each falling edge of the gate-value signal, including while gating is off. It stays set until a clear strobe. When a clear and a new event meet in the same cycle, the flag stays set.
- R12: The interrupt request is high only while both the event flag and the interrupt enable are high.
- R13: With toggle and single-pulse modes both on, exactly one full gate period is counted per arm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Counter clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_en_i | input | 1 | Counter enable |
| gate_en_i | input | 1 | Gating on: count only while the conditioned gate is high |
| gate_sel_i | input | 2 | Gate source code (0 pin, 1 comparator A, 2 comparator B, 3 off) |
| gate_pol_i | input | 1 | Invert the selected gate |
| toggle_en_i | input | 1 | Toggle (full period) mode |
| pulse_en_i | input | 1 | Single-pulse mode |
| go_set_i | input | 1 | Strobe that arms the one-shot |
| gate_pin_i | input | 1 | Pin gate source |
| cmp_i | input | 2 | Comparator outputs (bit 0 A, bit 1 B) |
| cmp_sync_i | input | 2 | Per-comparator synchronizer select |
| cnt_wr_i | input | 1 | Counter load strobe |
| cnt_wdata_i | input | WIDTH | Counter load value |
| irq_en_i | input | 1 | Interrupt enable |
| irq_clr_i | input | 1 | Event flag clear strobe |
| count_o | output | WIDTH | Counter value |
| go_o | output | 1 | Arm/done bit |
| gate_val_o | output | 1 | Conditioned gate level |
| irq_flag_o | output | 1 | Gate event flag |
| irq_o | output | 1 | Masked interrupt request |

## Verification
The bench builds the block with WIDTH set to 8 and SYNC_STAGES left at 2. The narrow counter lets a wrap from the top value to zero happen in a few clocks. The two-stage synchronizer makes the delay from a comparator edge to the gate short enough to check edge by edge. Pulse widths of a few clocks, and toggle periods of five clocks, give counts small enough that every gate-edge boundary of the one-shot and toggle stages can be pinned to an exact value.

// File: rtl/gc_pkg.sv
package gc_pkg;
  localparam int unsigned NUM_CMP = 2;

  typedef enum logic [1:0] {
    GSRC_PIN   = 2'd0,
    GSRC_CMP_A = 2'd1,
    GSRC_CMP_B = 2'd2,
    GSRC_OFF   = 2'd3
  } gate_src_e;
endpackage

// File: rtl/gc_gate_src.sv
module gc_gate_src
  import gc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               gate_pin_i,
  input  logic [NUM_CMP-1:0] cmp_i,
  input  logic [NUM_CMP-1:0] cmp_sync_i,
  input  gate_src_e          sel_i,
  output logic               gate_o
);
  logic [NUM_CMP-1:0] cmp_c;

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
    logic [SYNC_STAGES-1:0] sh_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= '0;
      else         sh_q <= {sh_q[SYNC_STAGES-2:0], cmp_i[g]};
    end
    assign cmp_c[g] = cmp_sync_i[g] ? sh_q[SYNC_STAGES-1] : cmp_i[g];
  end

  always_comb begin
    unique case (sel_i)
      GSRC_PIN:   gate_o = gate_pin_i;
      GSRC_CMP_A: gate_o = cmp_c[0];
      GSRC_CMP_B: gate_o = cmp_c[1];
      default:    gate_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/gc_gate_cond.sv
module gc_gate_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gate_raw_i,
  input  logic pol_i,
  input  logic toggle_en_i,
  input  logic pulse_en_i,
  input  logic go_set_i,
  input  logic irq_clr_i,
  output logic gate_val_o,
  output logic go_o,
  output logic flag_o
);
  logic g_pol, g_pol_q, g_rise;
  logic tff_q, tg, tg_q, tg_rise, tg_fall;
  logic go_q, run_q, gv_q, flag_q;

  assign g_pol   = gate_raw_i ^ pol_i;
  assign g_rise  = g_pol & ~g_pol_q;
  assign tg      = toggle_en_i ? tff_q : g_pol;
  assign tg_rise = tg & ~tg_q;
  assign tg_fall = ~tg & tg_q;

  // one-shot window opens combinationally on the armed rising edge
  assign gate_val_o = pulse_en_i ? (tg & (run_q | (go_q & ~tg_q))) : tg;
  assign go_o       = go_q;
  assign flag_o     = flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      g_pol_q <= 1'b0;
      tg_q    <= 1'b0;
      gv_q    <= 1'b0;
      tff_q   <= 1'b0;
    end else begin
      g_pol_q <= g_pol;
      tg_q    <= tg;
      gv_q    <= gate_val_o;
      if (!toggle_en_i) tff_q <= 1'b0;
      else if (g_rise)  tff_q <= ~tff_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      go_q  <= 1'b0;
      run_q <= 1'b0;
    end else if (!pulse_en_i) begin
      go_q  <= 1'b0;
      run_q <= 1'b0;
    end else if (run_q && tg_fall) begin
      go_q  <= 1'b0;
      run_q <= 1'b0;
    end else begin
      if (go_q && tg_rise) run_q <= 1'b1;
      if (go_set_i)        go_q  <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    flag_q <= 1'b0;
    else if (gv_q && !gate_val_o)   flag_q <= 1'b1;
    else if (irq_clr_i)             flag_q <= 1'b0;
  end

  AST_TFF_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    toggle_en_i && g_rise |=> tff_q != $past(tff_q)); // R6
  AST_TFF_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !toggle_en_i |=> !tff_q); // R7
  AST_GO_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && tg_fall |=> !go_o); // R8
  AST_GO_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pulse_en_i |=> !go_o); // R9
  AST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gv_q && !gate_val_o |=> flag_o); // R11
endmodule

// File: rtl/gc_counter.sv
module gc_counter #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             wr_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] count_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    count_o <= '0;
    else if (wr_i)  count_o <= wdata_i;
    else if (inc_i) count_o <= count_o + 1'b1;
  end

  AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && !wr_i |=> count_o == WIDTH'($past(count_o) + 1'b1)); // R2
  AST_COUNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i && !wr_i |=> $stable(count_o)); // R2
endmodule

// File: rtl/gated_counter.sv
module gated_counter
  import gc_pkg::*;
#(
  parameter int unsigned WIDTH       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_en_i,
  input  logic             gate_en_i,
  input  logic [1:0]       gate_sel_i,
  input  logic             gate_pol_i,
  input  logic             toggle_en_i,
  input  logic             pulse_en_i,
  input  logic             go_set_i,
  input  logic             gate_pin_i,
  input  logic [1:0]       cmp_i,
  input  logic [1:0]       cmp_sync_i,
  input  logic             cnt_wr_i,
  input  logic [WIDTH-1:0] cnt_wdata_i,
  input  logic             irq_en_i,
  input  logic             irq_clr_i,
  output logic [WIDTH-1:0] count_o,
  output logic             go_o,
  output logic             gate_val_o,
  output logic             irq_flag_o,
  output logic             irq_o
);
  logic gate_raw, gate_val, inc;

  gc_gate_src #(.SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .gate_pin_i (gate_pin_i),
    .cmp_i      (cmp_i),
    .cmp_sync_i (cmp_sync_i),
    .sel_i      (gate_src_e'(gate_sel_i)),
    .gate_o     (gate_raw)
  );

  gc_gate_cond u_cond (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .gate_raw_i  (gate_raw),
    .pol_i       (gate_pol_i),
    .toggle_en_i (toggle_en_i),
    .pulse_en_i  (pulse_en_i),
    .go_set_i    (go_set_i),
    .irq_clr_i   (irq_clr_i),
    .gate_val_o  (gate_val),
    .go_o        (go_o),
    .flag_o      (irq_flag_o)
  );

  assign inc        = cnt_en_i & (~gate_en_i | gate_val);
  assign gate_val_o = gate_val;
  assign irq_o      = irq_flag_o & irq_en_i;

  gc_counter #(.WIDTH(WIDTH)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .inc_i   (inc),
    .wr_i    (cnt_wr_i),
    .wdata_i (cnt_wdata_i),
    .count_o (count_o)
  );

  AST_IRQ_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_i |-> !irq_o); // R12
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> irq_flag_o); // R12
  AST_NO_GATED_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_en_i && !gate_val_o && !cnt_wr_i |=> $stable(count_o)); // R2
endmodule

// File: tb/gated_counter_tb_top.sv
`timescale 1ns/1ps
module gated_counter_tb_top;
  localparam int unsigned WIDTH = 8;
  localparam int SIG_CNT = 0, SIG_GO = 1, SIG_GV = 2, SIG_FLAG = 3, SIG_IRQ = 4;

  typedef struct {
    string req;
    int    sig;
    int    exp;
  } item_t;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic cnt_en_i = 0, gate_en_i = 0, gate_pol_i = 0, toggle_en_i = 0;
  logic pulse_en_i = 0, go_set_i = 0, gate_pin_i = 0, cnt_wr_i = 0;
  logic irq_en_i = 0, irq_clr_i = 0;
  logic [1:0] gate_sel_i = 2'd0, cmp_i = 2'd0, cmp_sync_i = 2'd0;
  logic [WIDTH-1:0] cnt_wdata_i = '0;
  logic [WIDTH-1:0] count_o;
  logic go_o, gate_val_o, irq_flag_o, irq_o;

  int checks = 0, errors = 0;
  bit done = 0;
  item_t sb_q[$];

  always #2 clk_i = ~clk_i;

  gated_counter #(.WIDTH(WIDTH), .SYNC_STAGES(2)) dut_i (
    .clk_i, .rst_ni, .cnt_en_i, .gate_en_i, .gate_sel_i, .gate_pol_i,
    .toggle_en_i, .pulse_en_i, .go_set_i, .gate_pin_i, .cmp_i, .cmp_sync_i,
    .cnt_wr_i, .cnt_wdata_i, .irq_en_i, .irq_clr_i,
    .count_o, .go_o, .gate_val_o, .irq_flag_o, .irq_o
  );

  function automatic int actual(int sig);
    case (sig)
      SIG_CNT:  return int'(count_o);
      SIG_GO:   return int'(go_o);
      SIG_GV:   return int'(gate_val_o);
      SIG_FLAG: return int'(irq_flag_o);
      default:  return int'(irq_o);
    endcase
  endfunction

  // monitor: items pushed during a cycle are compared at the next falling edge
  initial forever begin
    @(negedge clk_i);
    while (sb_q.size() > 0) begin
      item_t it;
      int a;
      it = sb_q.pop_front();
      a = actual(it.sig);
      checks++;
      if (a != it.exp) begin
        errors++;
        $display("FAIL %s sig%0d actual %0d expected %0d", it.req, it.sig, a, it.exp);
      end
    end
  end

  task automatic push_exp(string req, int sig, int exp);
    item_t it;
    it.req = req; it.sig = sig; it.exp = exp;
    sb_q.push_back(it);
  endtask

  task automatic cyc(int n = 1);
    repeat (n) begin @(negedge clk_i); #1; end
  endtask

  task automatic load(int v);
    cnt_wr_i = 1; cnt_wdata_i = WIDTH'(v);
    cyc(1);
    cnt_wr_i = 0;
  endtask

  task automatic clr_flag();
    irq_clr_i = 1; cyc(1); irq_clr_i = 0; cyc(1);
  endtask

  initial begin
    cyc(3);
    rst_ni = 1;
    push_exp("R1", SIG_CNT, 0); push_exp("R1", SIG_GO, 0);
    push_exp("R1", SIG_FLAG, 0); push_exp("R1", SIG_IRQ, 0);
    cyc(1);

    // plain gating from the pin
    gate_en_i = 1; cnt_en_i = 1; gate_sel_i = 2'd0;
    gate_pin_i = 1;
    push_exp("R10", SIG_GV, 1);
    cyc(5);
    gate_pin_i = 0;
    push_exp("R2", SIG_CNT, 5); push_exp("R11", SIG_FLAG, 1); push_exp("R12", SIG_IRQ, 0);
    cyc(1);
    irq_en_i = 1; push_exp("R12", SIG_IRQ, 1); cyc(1);
    irq_clr_i = 1; push_exp("R11", SIG_FLAG, 0); cyc(1);
    irq_clr_i = 0; push_exp("R12", SIG_IRQ, 0); cyc(1);
    cnt_en_i = 0; gate_pin_i = 1; cyc(3);
    push_exp("R2", SIG_CNT, 5);
    gate_pin_i = 0; cyc(1); clr_flag();

    // gating off: free counting, flag still live
    gate_en_i = 0; cnt_en_i = 1; cyc(4);
    cnt_en_i = 0; push_exp("R2", SIG_CNT, 9); cyc(1);
    gate_pin_i = 1; cyc(1); gate_pin_i = 0;
    push_exp("R11", SIG_FLAG, 1); push_exp("R10", SIG_GV, 0); cyc(1); clr_flag();
    load(8'hFE); cnt_en_i = 1; cyc(3);
    cnt_en_i = 0; push_exp("R2", SIG_CNT, 1); cyc(1);
    cnt_en_i = 1; cnt_wr_i = 1; cnt_wdata_i = 8'h40;
    push_exp("R2", SIG_CNT, 8'h40); cyc(1);
    cnt_wr_i = 0; cnt_en_i = 0;

    // polarity
    gate_en_i = 1; load(0);
    gate_pol_i = 1; gate_pin_i = 1; cnt_en_i = 1;
    push_exp("R5", SIG_GV, 0); cyc(3);
    gate_pin_i = 0; push_exp("R5", SIG_GV, 1); cyc(3);
    cnt_en_i = 0; push_exp("R5", SIG_CNT, 3); cyc(1);
    gate_pol_i = 0; cyc(1); clr_flag();

    // comparator A through the synchronizer, pin ignored
    load(0); gate_sel_i = 2'd1; cmp_sync_i = 2'b01; cnt_en_i = 1;
    gate_pin_i = 1; cmp_i[0] = 1; cyc(6);
    cmp_i[0] = 0; gate_pin_i = 0; cyc(4);
    cnt_en_i = 0; push_exp("R4", SIG_CNT, 6); cyc(1); clr_flag();
    cmp_i[0] = 1; push_exp("R4", SIG_GV, 0); cyc(1);
    push_exp("R4", SIG_GV, 1); cyc(1);
    cmp_i[0] = 0; cyc(3); clr_flag();

    // comparator B bypassing the synchronizer, A ignored
    load(0); gate_sel_i = 2'd2; cmp_sync_i = 2'b00;
    cmp_i = 2'b11; cnt_en_i = 1; cyc(3);
    cmp_i[1] = 0; cnt_en_i = 0; push_exp("R3", SIG_CNT, 3); cyc(1);
    gate_sel_i = 2'd3; gate_pin_i = 1; cmp_i = 2'b11;
    push_exp("R3", SIG_GV, 0); cyc(1);
    cmp_i = 2'b00; gate_pin_i = 0; gate_sel_i = 2'd0; cyc(1); clr_flag();

    // toggle mode: one full period
    load(0); toggle_en_i = 1; cnt_en_i = 1;
    gate_pin_i = 1; cyc(2); gate_pin_i = 0; cyc(3);
    gate_pin_i = 1; cyc(2); gate_pin_i = 0; cyc(3);
    cnt_en_i = 0; push_exp("R6", SIG_CNT, 5); cyc(1); clr_flag();
    gate_pin_i = 1; cyc(1); gate_pin_i = 0;
    push_exp("R6", SIG_GV, 1); cyc(1);
    toggle_en_i = 0; cyc(1);
    toggle_en_i = 1; push_exp("R7", SIG_GV, 0); cyc(1);
    toggle_en_i = 0; cyc(1); clr_flag();

    // single-pulse mode
    load(0); pulse_en_i = 1; cnt_en_i = 1;
    gate_pin_i = 1; cyc(3); gate_pin_i = 0; cyc(2);
    push_exp("R8", SIG_CNT, 0); cyc(1);
    go_set_i = 1; push_exp("R8", SIG_GO, 1); cyc(1);
    go_set_i = 0; gate_pin_i = 1; cyc(4);
    gate_pin_i = 0; push_exp("R8", SIG_GO, 0); push_exp("R8", SIG_CNT, 4); cyc(1);
    gate_pin_i = 1; cyc(3); gate_pin_i = 0; cyc(2);
    push_exp("R8", SIG_CNT, 4); cyc(1); clr_flag();
    go_set_i = 1; cyc(1); go_set_i = 0;
    pulse_en_i = 0; push_exp("R9", SIG_GO, 0); cyc(1);
    go_set_i = 1; cyc(1); go_set_i = 0;
    push_exp("R9", SIG_GO, 0); cyc(1);

    // toggle and single-pulse together
    load(0); toggle_en_i = 1; pulse_en_i = 1;
    go_set_i = 1; cyc(1); go_set_i = 0; cnt_en_i = 1;
    gate_pin_i = 1; cyc(2); gate_pin_i = 0; cyc(3);
    gate_pin_i = 1; cyc(2); gate_pin_i = 0; cyc(3);
    gate_pin_i = 1; cyc(2); gate_pin_i = 0; cyc(3);
    cnt_en_i = 0; push_exp("R13", SIG_CNT, 5); push_exp("R13", SIG_GO, 0); cyc(1);
    toggle_en_i = 0; pulse_en_i = 0; cyc(1); clr_flag();

    // clear meets new event
    gate_pin_i = 1; cyc(2);
    gate_pin_i = 0; irq_clr_i = 1; push_exp("R11", SIG_FLAG, 1); cyc(1);
    irq_clr_i = 0; cyc(1);
    irq_clr_i = 1; push_exp("R11", SIG_FLAG, 0); cyc(1);
    irq_clr_i = 0;

    cyc(3);
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule